// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the gatekeeper that sits between the command decoder of a serial NOR flash device and its program/erase engine. For every decoded modifying command (status write, page program, sector erase, bulk erase) it returns a one-cycle accept or reject verdict. It holds the protection-related part of the status byte: the write-enable latch, a sticky status-lock bit, and a three-bit zone code that selects how much of the array, counted from the top, is guarded.

Protection has two layers. The zone code alone gives a software-controlled guarded area that rejects program and erase commands aimed at it. When the status-lock bit is set while the active-low write-protect pin is low, the controller enters a hard-locked state. In that state status writes are refused, so the zone code cannot be changed and the guarded area is also protected by hardware. The hard lock can be entered in either order: set the bit and then pull the pin low, or pull the pin low and then set the bit. It ends only when the pin goes high. With the pin held high, only the zone code can protect anything.

Top module: `flash_protect_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the status byte to 0x00 and drives `cmd_accept`, `cmd_reject` and `hard_locked` low.
- R2: A `wren` pulse sets the write-enable latch (status bit 1) at the next edge. Every command (`cmd_valid` high) clears it at the next edge, whether accepted or rejected. When both arrive in the same cycle, the latch ends cleared.
- R3: Any command issued while the write-enable latch is 0 is rejected.
- R4: With the lock bit (status bit 7) at 0, a status write (`cmd_kind`=0) with the latch set is accepted at either pin level. It loads `wr_lock` into bit 7 and `wr_zone` into bits 4:2. Bits 6:5 and 0 always read 0.
- R5: With the lock bit at 1 and `wp_n` high, a status write with the latch set is accepted and updates bits 7 and 4:2.
- R6: With the lock bit at 1 and `wp_n` low, a status write is rejected even with the latch set, and bits 7 and 4:2 keep their values.
- R7: `hard_locked` is high exactly when the lock bit is 1 and `wp_n` is low, whichever became true first. While `wp_n` stays low it cannot drop, and raising `wp_n` ends it.
- R8: The guarded area depends on the zone code Z, counting 16 sectors indexed 0..15 by `cmd_sector`. Z=0 guards nothing. Z=1..4 guard the top 1, 2, 4 and 8 sectors. Z=5..7 guard all 16.
- R9: Page program (`cmd_kind`=1) and sector erase (`cmd_kind`=2) with the latch set are rejected inside the guarded area and accepted outside it, whether or not the hard lock is active.
- R10: Bulk erase (`cmd_kind`=3) is rejected whenever the zone code is nonzero. With the latch set and zone code 0 it is accepted.
- R11: Each command yields exactly one of `cmd_accept` or `cmd_reject`, high for one cycle, at the edge after the command. Neither is high in any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Active-low write-protect pin level |
| wren | input | 1 | Write-enable command strobe |
| cmd_valid | input | 1 | Decoded modifying command strobe |
| cmd_kind | input | 2 | 0 status write, 1 page program, 2 sector erase, 3 bulk erase |
| cmd_sector | input | SEC_W | Sector index of the target address (top address bits) |
| wr_lock | input | 1 | New lock bit carried by a status write |
| wr_zone | input | 3 | New zone code carried by a status write |
| cmd_accept | output | 1 | One-cycle accept verdict |
| cmd_reject | output | 1 | One-cycle reject verdict |
| status | output | 8 | Status byte: bit 7 lock, bits 4:2 zone, bit 1 write-enable latch |
| hard_locked | output | 1 | Hardware-protected state indicator |

## Verification
The bench drives both entry orders into the hard lock. A controller that latched the lock only on one transition would miss the other order. It also tries to clear the lock bit with a status write while the pin is low, which a design that checked only the latch would let through. A sweep of every zone code against every sector exposes off-by-one area boundaries and wrong saturation for codes 5 to 7. Same-cycle write-enable and command pulses check that the latch cannot survive a command, and a bulk erase under any nonzero zone code must still be refused.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        OP_WRSR = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_BULK = 2'd3
    } op_e;

    typedef struct packed {
        logic       lock;
        logic [2:0] zone;
        logic       wen;
    } guard_state_t;

    typedef struct packed {
        logic accept;
        logic reject;
    } verdict_t;

    function automatic logic [7:0] pack_status(guard_state_t s);
        return {s.lock, 2'b00, s.zone, s.wen, 1'b0};
    endfunction

endpackage

// File: rtl/fpc_zone_map.sv
module fpc_zone_map #(
    parameter int SEC_W = 4
) (
    input  logic [2:0]       zone,
    input  logic [SEC_W-1:0] sector,
    output logic             in_zone
);
    localparam int NSEC   = 1 << SEC_W;
    localparam int SPAN_W = SEC_W + 1;

    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] limit;
    logic [NSEC-1:0]   sec_hit;

    always_comb begin
        span = '0;
        if (zone != 3'd0) begin
            if ({29'd0, zone} > SEC_W)
                span = SPAN_W'(NSEC);
            else
                span = SPAN_W'(1) << (zone - 3'd1);
        end
    end

    assign limit = SPAN_W'(NSEC) - span;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        assign sec_hit[s] = (SPAN_W'(s) >= limit);
    end

    assign in_zone = sec_hit[sector];

endmodule

// File: rtl/fpc_decide.sv
module fpc_decide
    import fpc_pkg::*;
(
    input  logic         cmd_valid,
    input  op_e          op,
    input  guard_state_t st,
    input  logic         wp_n,
    input  logic         in_zone,
    output verdict_t     verdict,
    output logic         status_wr
);
    logic ok;

    always_comb begin
        ok = 1'b0;
        unique case (op)
            OP_WRSR: ok = st.wen && !(st.lock && !wp_n);
            OP_PROG,
            OP_SECT: ok = st.wen && !in_zone;
            OP_BULK: ok = st.wen && (st.zone == 3'd0);
            default: ok = 1'b0;
        endcase
    end

    always_comb begin
        verdict.accept = cmd_valid && ok;
        verdict.reject = cmd_valid && !ok;
        status_wr      = cmd_valid && ok && (op == OP_WRSR);
    end

endmodule

// File: rtl/fpc_state.sv
module fpc_state
    import fpc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wren,
    input  logic         cmd_valid,
    input  logic         status_wr,
    input  logic         new_lock,
    input  logic [2:0]   new_zone,
    output guard_state_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (cmd_valid)
                st.wen <= 1'b0;
            else if (wren)
                st.wen <= 1'b1;
            if (status_wr) begin
                st.lock <= new_lock;
                st.zone <= new_zone;
            end
        end
    end

endmodule

// File: rtl/flash_protect_ctrl.sv
module flash_protect_ctrl
    import fpc_pkg::*;
#(
    parameter int SEC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wp_n,
    input  logic             wren,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic [SEC_W-1:0] cmd_sector,
    input  logic             wr_lock,
    input  logic [2:0]       wr_zone,
    output logic             cmd_accept,
    output logic             cmd_reject,
    output logic [7:0]       status,
    output logic             hard_locked
);
    guard_state_t st;
    verdict_t     verdict_d;
    verdict_t     verdict_q;
    logic         in_zone;
    logic         status_wr;

    fpc_zone_map #(.SEC_W(SEC_W)) u_zone (
        .zone    (st.zone),
        .sector  (cmd_sector),
        .in_zone (in_zone)
    );

    fpc_decide u_decide (
        .cmd_valid (cmd_valid),
        .op        (op_e'(cmd_kind)),
        .st        (st),
        .wp_n      (wp_n),
        .in_zone   (in_zone),
        .verdict   (verdict_d),
        .status_wr (status_wr)
    );

    fpc_state u_state (
        .clk       (clk),
        .rst       (rst),
        .wren      (wren),
        .cmd_valid (cmd_valid),
        .status_wr (status_wr),
        .new_lock  (wr_lock),
        .new_zone  (wr_zone),
        .st        (st)
    );

    always_ff @(posedge clk) begin
        if (rst) verdict_q <= '0;
        else     verdict_q <= verdict_d;
    end

    assign cmd_accept  = verdict_q.accept;
    assign cmd_reject  = verdict_q.reject;
    assign status      = pack_status(st);
    assign hard_locked = st.lock && !wp_n;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       wren,
    input logic       cmd_valid,
    input logic [1:0] cmd_kind,
    input logic       cmd_accept,
    input logic       cmd_reject,
    input logic [7:0] status,
    input logic       hard_locked
);
    a_r11_one_verdict: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_accept, cmd_reject}));

    a_r11_verdict_follows: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (cmd_accept || cmd_reject));

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !(cmd_accept || cmd_reject));

    a_r2_wen_cleared: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !status[1]);

    a_r2_wen_set: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && wren) |=> status[1]);

    a_r3_need_wen: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !status[1]) |=> cmd_reject);

    a_r6_locked_write: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd0 && status[7] && !wp_n)
        |=> (cmd_reject && status[7:2] == $past(status[7:2])));

    a_r7_pin_releases: assert property (@(posedge clk) disable iff (rst)
        wp_n |-> !hard_locked);

    a_r7_sticky_low: assert property (@(posedge clk) disable iff (rst)
        hard_locked |=> (wp_n || hard_locked));

    a_r10_bulk_guarded: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd3 && status[4:2] != 3'd0) |=> cmd_reject);

    a_r4_fixed_zero: assert property (@(posedge clk) disable iff (rst)
        (status[6:5] == 2'b00 && !status[0]));

endmodule

bind flash_protect_ctrl fpc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wp_n        (wp_n),
    .wren        (wren),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_accept  (cmd_accept),
    .cmd_reject  (cmd_reject),
    .status      (status),
    .hard_locked (hard_locked)
);

// File: tb/tb_flash_protect_ctrl.sv
`timescale 1ns/1ps
module tb_flash_protect_ctrl;
    localparam int SEC_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wp_n = 1'b1;
    logic             wren = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_kind = 2'd0;
    logic [SEC_W-1:0] cmd_sector = '0;
    logic             wr_lock = 1'b0;
    logic [2:0]       wr_zone = 3'd0;
    logic             cmd_accept, cmd_reject, hard_locked;
    logic [7:0]       status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    flash_protect_ctrl #(.SEC_W(SEC_W)) dut (
        .clk(clk), .rst(rst), .wp_n(wp_n), .wren(wren),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_sector(cmd_sector),
        .wr_lock(wr_lock), .wr_zone(wr_zone),
        .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .status(status), .hard_locked(hard_locked)
    );

    // Behavioural reference model
    int    m_lock, m_zone, m_wen, m_acc, m_rej;
    string m_tag = "R11";

    function automatic int guarded(int zone, int sec);
        int cnt;
        if (zone == 0) return 0;
        if (zone >= 5) return 1;
        cnt = 16 >> (5 - zone);
        return (sec >= 16 - cnt) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int ok;
        started = 1;
        if (rst) begin
            m_lock = 0; m_zone = 0; m_wen = 0; m_acc = 0; m_rej = 0;
            m_tag = "R1";
        end else begin
            ok = 0;
            if (cmd_valid) begin
                if (m_wen == 0) begin
                    ok = 0; m_tag = "R3";
                end else if (cmd_kind == 2'd0) begin
                    if (m_lock == 1 && wp_n == 0) begin ok = 0; m_tag = "R6"; end
                    else begin ok = 1; m_tag = (m_lock == 1) ? "R5" : "R4"; end
                end else if (cmd_kind == 2'd3) begin
                    ok = (m_zone == 0); m_tag = "R10";
                end else begin
                    ok = !guarded(m_zone, int'(cmd_sector)); m_tag = "R9";
                end
            end else begin
                m_tag = "R11";
            end
            m_acc = (cmd_valid && ok) ? 1 : 0;
            m_rej = (cmd_valid && !ok) ? 1 : 0;
            if (cmd_valid && ok && cmd_kind == 2'd0) begin
                m_lock = int'(wr_lock); m_zone = int'(wr_zone);
            end
            if (cmd_valid) m_wen = 0;
            else if (wren) m_wen = 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check({m_tag, " accept"}, int'(cmd_accept), m_acc);
            check({m_tag, " reject"}, int'(cmd_reject), m_rej);
            check("R4 status", int'(status),
                  (m_lock << 7) | (m_zone << 2) | (m_wen << 1));
            check("R7 hard_locked", int'(hard_locked),
                  (m_lock == 1 && wp_n == 1'b0) ? 1 : 0);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        cmd_valid = 0; wren = 0;
        tick();
    endtask

    task automatic enable();
        wren = 1; cmd_valid = 0;
        tick();
        wren = 0;
    endtask

    task automatic issue(input int kind, input int sec, input int lk, input int zn);
        cmd_valid = 1; cmd_kind = 2'(kind); cmd_sector = SEC_W'(sec);
        wr_lock = lk[0]; wr_zone = 3'(zn);
        tick();
        cmd_valid = 0;
    endtask

    initial begin
        repeat (3) tick();
        check("R1 status after reset", int'(status), 0);
        check("R1 verdicts after reset", int'({cmd_accept, cmd_reject}), 0);
        rst = 0;
        idle();

        enable();
        check("R2 latch set", int'(status[1]), 1);
        wp_n = 0;
        issue(0, 0, 0, 1);                    // R4: lock 0, pin low, accepted
        check("R4 write accepted pin low", int'(cmd_accept), 1);
        issue(1, 0, 0, 0);                    // R3: no latch
        check("R3 no latch reject", int'(cmd_reject), 1);
        enable(); issue(1, 15, 0, 0);         // guarded by zone 1
        check("R9 top sector guarded", int'(cmd_reject), 1);
        enable(); issue(1, 14, 0, 0);
        check("R9 sector 14 open", int'(cmd_accept), 1);

        // R2: same-cycle enable and command
        wren = 1; issue(2, 0, 0, 0); wren = 0;
        check("R2 latch cleared by command", int'(status[1]), 0);

        // R5 then R7 pin-after-bit order
        wp_n = 1;
        enable(); issue(0, 0, 1, 2);
        check("R5 write accepted pin high", int'(status[7:2]), 6'b100010);
        check("R7 not locked pin high", int'(hard_locked), 0);
        wp_n = 0; tick();
        check("R7 locked after pin low", int'(hard_locked), 1);
        enable(); issue(0, 0, 0, 0);
        check("R6 locked write rejected", int'(cmd_reject), 1);
        check("R6 bits kept", int'(status[7:2]), 6'b100010);
        enable(); issue(2, 13, 0, 0);
        check("R9 open sector in hard lock", int'(cmd_accept), 1);
        enable(); issue(2, 14, 0, 0);
        check("R9 guarded sector in hard lock", int'(cmd_reject), 1);
        enable(); issue(3, 0, 0, 0);
        check("R10 bulk refused zone 2", int'(cmd_reject), 1);
        wp_n = 1; tick();
        check("R7 released by pin", int'(hard_locked), 0);
        enable(); issue(0, 0, 0, 0);
        enable(); issue(3, 0, 0, 0);
        check("R10 bulk accepted zone 0", int'(cmd_accept), 1);

        // R7 bit-after-pin order
        wp_n = 0; tick();
        enable(); issue(0, 0, 1, 0);
        check("R7 locked bit after pin", int'(hard_locked), 1);
        wp_n = 1; tick();
        enable(); issue(0, 0, 0, 0);

        // R8 sweep of zone codes and sectors
        for (int z = 0; z < 8; z++) begin
            enable(); issue(0, 0, 0, z);
            for (int s = 0; s < 16; s++) begin
                enable(); issue(1, s, 0, 0);
                check($sformatf("R8 zone %0d sector %0d", z, s),
                      int'(cmd_reject), guarded(z, s));
            end
        end

        // Mixed random traffic, compared every clock by the model
        for (int i = 0; i < 4000; i++) begin
            wren       = ($urandom % 3) == 0;
            cmd_valid  = ($urandom % 3) == 0;
            cmd_kind   = 2'($urandom);
            cmd_sector = SEC_W'($urandom);
            wr_lock    = 1'($urandom);
            wr_zone    = 3'($urandom);
            if (($urandom % 16) == 0) wp_n = ~wp_n;
            tick();
        end
        idle();
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule